// File: doc/BRIEF.md
# Rail Overvoltage / Undervoltage Supervisor

This block watches several regulated output rails through digitized voltage samples. Each rail has its own programmable nominal code. Every sample of every rail is compared with four limits derived from that nominal: an upper and a lower warning limit, and an upper and a lower shutdown limit. Warnings are reported straight away. They never stop the rails.

A shutdown-level violation counts only if it persists. A digital persistence filter counts consecutive strobed samples, and overvoltage and undervoltage each have their own length, with undervoltage typically much longer. When a violation qualifies, the block latches the per-rail trip flag and requests shutdown of all rails from the sequencer. After a fixed hold-off it lets the rails come back up. The number of such restarts is bounded. Once the budget is spent, the next qualified fault locks the block in shutdown until an explicit clear. If an overvoltage trip is part of that locking fault, the block also raises a request to switch off the upstream intermediate bus converter.

The controller is a three-state machine:
- `MON_RUN`: monitoring is active.
- `MON_HOLDOFF`: the rails are held off for a timed interval.
- `MON_LOCKED`: the block is latched off until cleared.

Its transitions are:
- *trip* (`MON_RUN` to `MON_HOLDOFF`): a fault qualifies while restart budget remains.
- *lockout* (`MON_RUN` to `MON_LOCKED`): a fault qualifies with no budget left.
- *restart* (`MON_HOLDOFF` to `MON_RUN`): the hold-off timer expires.
- *clear* (`MON_LOCKED` to `MON_RUN`): `fault_clear` is seen while locked.

Top module: `rail_ov_uv_monitor`

## Requirements
- R1: For a nominal code n, the shutdown delta is d = (n>>4)+(n>>5)+(n>>8)+(n>>9) and the warning delta is d>>1. A sample s is an overvoltage at a tier when s >= n + delta, and an undervoltage when s <= n - delta. Both comparisons are inclusive. Rail i occupies bits [i*CODE_W +: CODE_W] of `smp_code` and of `nom_code`.
- R2: `ov_warn[i]` and `uv_warn[i]` show the warning-tier comparison of the most recent strobed sample of rail i. They update on the clock edge at which `smp_valid` is high, in every controller state, and on their own they never cause a shutdown.
- R3: While in `MON_RUN`, OV_QUAL consecutive strobed samples of rail i at or above the overvoltage shutdown limit set `ov_trip[i]` and raise `shutdown_req` in the cycle after the last such sample. Clock cycles without `smp_valid` neither advance nor reset the count.
- R4: The same holds for undervoltage with UV_QUAL samples, and the result is reported on `uv_trip[i]`.
- R5: A strobed sample back inside a shutdown limit restarts that rail's count for that direction from zero.
- R6: A fault that qualifies while fewer than MAX_RETRY restarts have been used holds `shutdown_req` high for exactly RESTART_CYC cycles. The block then returns to monitoring with all trip flags cleared and one restart consumed. Samples taken while shut down are not counted, so qualification starts afresh after the restart.
- R7: A fault that qualifies after MAX_RETRY restarts holds `shutdown_req` and `fault_locked` high until `fault_clear` is sampled high. The clear drops both signals, clears the trip flags and restores the full restart budget. `fault_clear` has no effect in any other state.
- R8: `bus_off_req` rises together with `fault_locked` when the locking fault includes an overvoltage trip. It stays low for a lockout caused only by undervoltage, and it clears with the clear.
- R9: While `rst_n` is low, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe for all rails |
| smp_code | input | N_RAILS*CODE_W | Packed rail samples, rail 0 in the low bits |
| nom_code | input | N_RAILS*CODE_W | Packed nominal codes, rail 0 in the low bits |
| fault_clear | input | 1 | Releases a locked shutdown |
| ov_warn | output | N_RAILS | Per-rail overvoltage warning |
| uv_warn | output | N_RAILS | Per-rail undervoltage warning |
| ov_trip | output | N_RAILS | Per-rail qualified overvoltage fault |
| uv_trip | output | N_RAILS | Per-rail qualified undervoltage fault |
| shutdown_req | output | 1 | Request to the sequencer to turn off all rails |
| fault_locked | output | 1 | Restart budget exhausted, latched off |
| bus_off_req | output | 1 | Request to turn off the intermediate bus converter |

## Verification
The bench drives samples exactly on each limit and one code inside it. A design with a strict comparison, or with the wrong shift terms, would miss the trip or warn one code early. It interrupts a run of violations one sample short of qualification, and it spaces strobes with idle cycles. A filter that counts clock cycles, or that fails to restart its count, would trip early. It keeps feeding undervoltage samples through the hold-off and checks that qualification restarts afresh, that the hold-off lasts exactly RESTART_CYC cycles, and that a clear pulsed during hold-off changes nothing. It exhausts the restart budget twice: once through an overvoltage, where the bus converter request must rise, and once through undervoltage only, where it must stay low. This exposes a lockout that comes one retry early or late, or a budget that the clear does not refill.

// File: rtl/rmon_pkg.sv
package rmon_pkg;

    typedef enum logic [1:0] {
        MON_RUN     = 2'd0,
        MON_HOLDOFF = 2'd1,
        MON_LOCKED  = 2'd2
    } mon_state_t;

    typedef struct packed {
        logic ov_sd;
        logic uv_sd;
        logic ov_wn;
        logic uv_wn;
    } rail_cmp_t;

endpackage

// File: rtl/rmon_thresh.sv
module rmon_thresh #(
    parameter int CODE_W = 10
) (
    input  logic [CODE_W-1:0]  nom,
    input  logic [CODE_W-1:0]  smp,
    output rmon_pkg::rail_cmp_t cmp
);
    localparam int EW = CODE_W + 1;

    logic [EW-1:0] n_ext;
    logic [EW-1:0] s_ext;
    logic [EW-1:0] d_sd;
    logic [EW-1:0] d_wn;
    logic [EW-1:0] hi_sd;
    logic [EW-1:0] hi_wn;
    logic [EW-1:0] lo_sd;
    logic [EW-1:0] lo_wn;

    assign n_ext = {1'b0, nom};
    assign s_ext = {1'b0, smp};

    // Tenth of nominal, approximated by four shifted terms (~9.96 %).
    assign d_sd  = (n_ext >> 4) + (n_ext >> 5) + (n_ext >> 8) + (n_ext >> 9);
    assign d_wn  = d_sd >> 1;

    assign hi_sd = n_ext + d_sd;
    assign hi_wn = n_ext + d_wn;
    assign lo_sd = n_ext - d_sd;
    assign lo_wn = n_ext - d_wn;

    always_comb begin
        cmp.ov_sd = (s_ext >= hi_sd);
        cmp.ov_wn = (s_ext >= hi_wn);
        cmp.uv_sd = (s_ext <= lo_sd);
        cmp.uv_wn = (s_ext <= lo_wn);
    end
endmodule

// File: rtl/rmon_qual.sv
module rmon_qual #(
    parameter int QUAL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic stb,
    input  logic viol,
    output logic fire
);
    localparam int CW = (QUAL < 2) ? 1 : $clog2(QUAL + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

    logic [CW-1:0] cnt_q;

    assign fire = en && stb && viol && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (stb) begin
            if (!viol || fire) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/rmon_ctrl.sv
module rmon_ctrl
    import rmon_pkg::*;
#(
    parameter int N_RAILS     = 4,
    parameter int RESTART_CYC = 1000,
    parameter int MAX_RETRY   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RAILS-1:0] ov_fire,
    input  logic [N_RAILS-1:0] uv_fire,
    input  logic               fault_clear,
    output logic               mon_en,
    output logic [N_RAILS-1:0] ov_trip,
    output logic [N_RAILS-1:0] uv_trip,
    output logic               shutdown_req,
    output logic               fault_locked,
    output logic               bus_off_req
);
    localparam int TW = $clog2(RESTART_CYC + 1);
    localparam int RW = $clog2(MAX_RETRY + 2);

    mon_state_t        state_q;
    mon_state_t        state_d;
    logic [TW-1:0]     tmr_q;
    logic [RW-1:0]     retry_q;
    logic [N_RAILS-1:0] ov_trip_q;
    logic [N_RAILS-1:0] uv_trip_q;
    logic              bus_off_q;
    logic              any_fire;
    logic              budget_left;
    logic              holdoff_done;
    logic              entering_run;

    assign any_fire     = (|ov_fire) || (|uv_fire);
    assign budget_left  = (retry_q < RW'(MAX_RETRY));
    assign holdoff_done = (tmr_q == TW'(RESTART_CYC - 1));
    assign entering_run = (state_d == MON_RUN) && (state_q != MON_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_RUN: begin
                if (any_fire) begin
                    state_d = budget_left ? MON_HOLDOFF : MON_LOCKED;
                end
            end
            MON_HOLDOFF: begin
                if (holdoff_done) begin
                    state_d = MON_RUN;
                end
            end
            MON_LOCKED: begin
                if (fault_clear) begin
                    state_d = MON_RUN;
                end
            end
            default: state_d = MON_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MON_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != MON_HOLDOFF) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q <= '0;
        end else if (state_q == MON_RUN && any_fire && budget_left) begin
            retry_q <= retry_q + RW'(1);
        end else if (state_q == MON_LOCKED && fault_clear) begin
            retry_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || entering_run) begin
            ov_trip_q <= '0;
            uv_trip_q <= '0;
        end else if (state_q == MON_RUN) begin
            ov_trip_q <= ov_trip_q | ov_fire;
            uv_trip_q <= uv_trip_q | uv_fire;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_off_q <= 1'b0;
        end else if (state_q == MON_RUN && any_fire && !budget_left) begin
            bus_off_q <= |ov_fire;
        end else if (state_q == MON_LOCKED && fault_clear) begin
            bus_off_q <= 1'b0;
        end
    end

    always_comb begin
        mon_en       = 1'b0;
        shutdown_req = 1'b0;
        fault_locked = 1'b0;
        unique case (state_q)
            MON_RUN:     mon_en = 1'b1;
            MON_HOLDOFF: shutdown_req = 1'b1;
            MON_LOCKED: begin
                shutdown_req = 1'b1;
                fault_locked = 1'b1;
            end
            default: mon_en = 1'b0;
        endcase
    end

    assign ov_trip     = ov_trip_q;
    assign uv_trip     = uv_trip_q;
    assign bus_off_req = bus_off_q;
endmodule

// File: rtl/rail_ov_uv_monitor.sv
module rail_ov_uv_monitor #(
    parameter int N_RAILS     = 4,
    parameter int CODE_W      = 10,
    parameter int OV_QUAL     = 3,
    parameter int UV_QUAL     = 40,
    parameter int RESTART_CYC = 1000,
    parameter int MAX_RETRY   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        smp_valid,
    input  logic [N_RAILS*CODE_W-1:0]   smp_code,
    input  logic [N_RAILS*CODE_W-1:0]   nom_code,
    input  logic                        fault_clear,
    output logic [N_RAILS-1:0]          ov_warn,
    output logic [N_RAILS-1:0]          uv_warn,
    output logic [N_RAILS-1:0]          ov_trip,
    output logic [N_RAILS-1:0]          uv_trip,
    output logic                        shutdown_req,
    output logic                        fault_locked,
    output logic                        bus_off_req
);
    logic               mon_en;
    logic [N_RAILS-1:0] ov_fire;
    logic [N_RAILS-1:0] uv_fire;

    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
        rmon_pkg::rail_cmp_t cmp;
        logic ow_q;
        logic uw_q;

        rmon_thresh #(.CODE_W(CODE_W)) u_thr (
            .nom (nom_code[g*CODE_W +: CODE_W]),
            .smp (smp_code[g*CODE_W +: CODE_W]),
            .cmp (cmp)
        );

        rmon_qual #(.QUAL(OV_QUAL)) u_ovq (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (mon_en),
            .stb   (smp_valid),
            .viol  (cmp.ov_sd),
            .fire  (ov_fire[g])
        );

        rmon_qual #(.QUAL(UV_QUAL)) u_uvq (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (mon_en),
            .stb   (smp_valid),
            .viol  (cmp.uv_sd),
            .fire  (uv_fire[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ow_q <= 1'b0;
                uw_q <= 1'b0;
            end else if (smp_valid) begin
                ow_q <= cmp.ov_wn;
                uw_q <= cmp.uv_wn;
            end
        end

        assign ov_warn[g] = ow_q;
        assign uv_warn[g] = uw_q;
    end

    rmon_ctrl #(
        .N_RAILS     (N_RAILS),
        .RESTART_CYC (RESTART_CYC),
        .MAX_RETRY   (MAX_RETRY)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ov_fire      (ov_fire),
        .uv_fire      (uv_fire),
        .fault_clear  (fault_clear),
        .mon_en       (mon_en),
        .ov_trip      (ov_trip),
        .uv_trip      (uv_trip),
        .shutdown_req (shutdown_req),
        .fault_locked (fault_locked),
        .bus_off_req  (bus_off_req)
    );
endmodule

// File: rtl/rmon_checker.sv
module rmon_checker #(
    parameter int N_RAILS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               smp_valid,
    input logic               fault_clear,
    input logic [N_RAILS-1:0] ov_warn,
    input logic [N_RAILS-1:0] uv_warn,
    input logic [N_RAILS-1:0] ov_trip,
    input logic [N_RAILS-1:0] uv_trip,
    input logic               shutdown_req,
    input logic               fault_locked,
    input logic               bus_off_req
);
    AST_WARN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp_valid) |-> ($stable(ov_warn) && $stable(uv_warn))); // R2

    AST_SHDN_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> $past(smp_valid)); // R3

    AST_SHDN_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_req) |-> ((ov_trip | uv_trip) != '0)); // R4

    AST_NO_TRIP_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !shutdown_req |-> ((ov_trip | uv_trip) == '0)); // R6

    AST_TRIPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_req && $past(shutdown_req)) |-> ($stable(ov_trip) && $stable(uv_trip))); // R6

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_locked && !fault_clear) |=> fault_locked); // R7

    AST_UNLOCK_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_locked) |-> $past(fault_clear)); // R7

    AST_LOCK_IS_SHDN: assert property (@(posedge clk) disable iff (!rst_n)
        fault_locked |-> shutdown_req); // R7

    AST_BUSOFF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off_req |-> fault_locked); // R8

    AST_BUSOFF_OV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_off_req) |-> (ov_trip != '0)); // R8
endmodule

bind rail_ov_uv_monitor rmon_checker #(.N_RAILS(N_RAILS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .smp_valid    (smp_valid),
    .fault_clear  (fault_clear),
    .ov_warn      (ov_warn),
    .uv_warn      (uv_warn),
    .ov_trip      (ov_trip),
    .uv_trip      (uv_trip),
    .shutdown_req (shutdown_req),
    .fault_locked (fault_locked),
    .bus_off_req  (bus_off_req)
);

// File: tb/sim_rail_ov_uv_monitor.sv
`timescale 1ns/1ps
module sim_rail_ov_uv_monitor;
    localparam int NR   = 4;
    localparam int CW   = 10;
    localparam int OVQ  = 3;
    localparam int UVQ  = 12;
    localparam int RSTC = 20;
    localparam int MAXR = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic smp_valid;
    logic [NR*CW-1:0] smp_code;
    logic [NR*CW-1:0] nom_code;
    logic fault_clear;
    logic [NR-1:0] ov_warn, uv_warn, ov_trip, uv_trip;
    logic shutdown_req, fault_locked, bus_off_req;

    always #2.5 clk = ~clk;

    rail_ov_uv_monitor #(
        .N_RAILS(NR), .CODE_W(CW), .OV_QUAL(OVQ), .UV_QUAL(UVQ),
        .RESTART_CYC(RSTC), .MAX_RETRY(MAXR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .nom_code(nom_code), .fault_clear(fault_clear), .ov_warn(ov_warn),
        .uv_warn(uv_warn), .ov_trip(ov_trip), .uv_trip(uv_trip),
        .shutdown_req(shutdown_req), .fault_locked(fault_locked),
        .bus_off_req(bus_off_req)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit run_chk = 0;
    bit done = 0;
    int nv[NR] = '{512, 800, 300, 640};

    // ---------------- reference model (behavioural) ----------------
    int m_ovc[NR];
    int m_uvc[NR];
    logic [NR-1:0] m_ow, m_uw, m_ot, m_ut;
    int  m_st;       // 0 run, 1 hold-off, 2 locked
    int  m_tmr;
    int  m_used;
    bit  m_bo;

    function automatic int dsd(int n);
        return (n >> 4) + (n >> 5) + (n >> 8) + (n >> 9);
    endfunction
    function automatic int ovs(int n); return n + dsd(n); endfunction
    function automatic int uvs(int n); return n - dsd(n); endfunction
    function automatic int ovw(int n); return n + dsd(n) / 2; endfunction
    function automatic int uvw(int n); return n - dsd(n) / 2; endfunction

    function automatic logic [NR*CW-1:0] set_rail(logic [NR*CW-1:0] v, int r, int val);
        logic [NR*CW-1:0] o;
        o = v;
        o[r*CW +: CW] = CW'(val);
        return o;
    endfunction

    task automatic model_reset();
        for (int r = 0; r < NR; r++) begin
            m_ovc[r] = 0;
            m_uvc[r] = 0;
        end
        m_ow = '0; m_uw = '0; m_ot = '0; m_ut = '0;
        m_st = 0; m_tmr = 0; m_used = 0; m_bo = 0;
    endtask

    task automatic model_step();
        logic [NR-1:0] fo, fu;
        int n, s;
        fo = '0;
        fu = '0;
        for (int r = 0; r < NR; r++) begin
            n = int'(nom_code[r*CW +: CW]);
            s = int'(smp_code[r*CW +: CW]);
            if (m_st != 0) begin
                m_ovc[r] = 0;
                m_uvc[r] = 0;
            end else if (smp_valid) begin
                if (s >= ovs(n)) begin
                    if (m_ovc[r] + 1 == OVQ) begin fo[r] = 1'b1; m_ovc[r] = 0; end
                    else m_ovc[r] = m_ovc[r] + 1;
                end else m_ovc[r] = 0;
                if (s <= uvs(n)) begin
                    if (m_uvc[r] + 1 == UVQ) begin fu[r] = 1'b1; m_uvc[r] = 0; end
                    else m_uvc[r] = m_uvc[r] + 1;
                end else m_uvc[r] = 0;
            end
            if (smp_valid) begin
                m_ow[r] = (s >= ovw(n));
                m_uw[r] = (s <= uvw(n));
            end
        end
        if (m_st == 0) begin
            m_ot = m_ot | fo;
            m_ut = m_ut | fu;
            if ((fo | fu) != '0) begin
                if (m_used < MAXR) begin
                    m_used++;
                    m_st = 1;
                    m_tmr = 0;
                end else begin
                    m_st = 2;
                    m_bo = (fo != '0);
                end
            end
        end else if (m_st == 1) begin
            m_tmr++;
            if (m_tmr == RSTC) begin
                m_st = 0; m_ot = '0; m_ut = '0;
            end
        end else if (fault_clear) begin
            m_st = 0; m_ot = '0; m_ut = '0; m_used = 0; m_bo = 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && run_chk && !done) begin
            check("R2 ov_warn vs model", 32'(ov_warn), 32'(m_ow));
            check("R2 uv_warn vs model", 32'(uv_warn), 32'(m_uw));
            check("R3 ov_trip vs model", 32'(ov_trip), 32'(m_ot));
            check("R4 uv_trip vs model", 32'(uv_trip), 32'(m_ut));
            check("R6 shutdown_req vs model", 32'(shutdown_req), 32'(m_st != 0));
            check("R7 fault_locked vs model", 32'(fault_locked), 32'(m_st == 2));
            check("R8 bus_off_req vs model", 32'(bus_off_req), 32'(m_bo));
        end
    end

    int sd_run = 0;
    int last_run = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            sd_run = 0;
        end else if (shutdown_req) begin
            sd_run++;
        end else begin
            if (sd_run != 0) last_run = sd_run;
            sd_run = 0;
        end
    end

    task automatic strobe(input logic [NR*CW-1:0] v, input int gap);
        smp_code = v;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wait_run();
        while (shutdown_req) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        report();
    end

    logic [NR*CW-1:0] base;

    initial begin
        base = '0;
        for (int r = 0; r < NR; r++) base = set_rail(base, r, nv[r]);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        fault_clear = 1'b0;
        nom_code = base;
        smp_code = base;
        repeat (4) @(negedge clk);
        // R9: outputs low during reset
        check("R9 reset flags", 32'({ov_warn, uv_warn, ov_trip, uv_trip}), 32'h0);
        check("R9 reset shutdown/lock/busoff", 32'({shutdown_req, fault_locked, bus_off_req}), 32'h0);
        rst_n = 1'b1;
        run_chk = 1;
        @(negedge clk);

        // nominal samples
        repeat (3) strobe(base, 1);
        check("R2 no warnings at nominal", 32'({ov_warn, uv_warn}), 32'h0);

        // R1/R2: warnings exactly at limits
        strobe(set_rail(set_rail(base, 0, ovw(nv[0])), 1, uvw(nv[1])), 0);
        check("R2 ov_warn at limit", 32'(ov_warn), 32'h1);
        check("R2 uv_warn at limit", 32'(uv_warn), 32'h2);
        strobe(set_rail(set_rail(base, 0, ovw(nv[0]) - 1), 1, uvw(nv[1]) + 1), 0);
        check("R1 one code inside warning limits", 32'({ov_warn, uv_warn}), 32'h0);

        // R1: one code below OV shutdown never qualifies
        repeat (OVQ + 1) strobe(set_rail(base, 0, ovs(nv[0]) - 1), 0);
        check("R1 below OV shutdown limit", 32'(shutdown_req), 32'h0);
        check("R2 warning alone no shutdown", 32'(ov_warn), 32'h1);

        // R5: interrupted violation restarts count
        repeat (OVQ - 1) strobe(set_rail(base, 2, ovs(nv[2])), 2);
        strobe(base, 2);
        repeat (OVQ - 1) strobe(set_rail(base, 2, ovs(nv[2])), 2);
        strobe(base, 0);
        check("R5 interrupted OV run", 32'(shutdown_req), 32'h0);

        // R3: qualified OV with idle gaps between strobes
        repeat (OVQ - 1) strobe(set_rail(base, 2, ovs(nv[2])), 2);
        check("R3 one sample short", 32'(shutdown_req), 32'h0);
        strobe(set_rail(base, 2, ovs(nv[2])), 0);
        check("R3 OV shutdown asserted", 32'(shutdown_req), 32'h1);
        check("R3 ov_trip rail 2", 32'(ov_trip), 32'h4);

        // R6/R7: UV samples and a clear pulse during hold-off are ignored
        fault_clear = 1'b1;
        strobe(set_rail(base, 3, uvs(nv[3])), 0);
        fault_clear = 1'b0;
        check("R7 clear outside lock ignored", 32'({shutdown_req, fault_locked}), 32'h2);
        while (shutdown_req) strobe(set_rail(base, 3, uvs(nv[3])), 0);
        @(negedge clk);
        check("R6 hold-off length", 32'(last_run), 32'(RSTC));
        check("R6 trips cleared after restart", 32'({ov_trip, uv_trip}), 32'h0);

        // R4: UV qualification after restart starts from zero
        repeat (UVQ - 2) strobe(set_rail(base, 3, uvs(nv[3])), 1);
        check("R6 hold-off samples not counted", 32'(shutdown_req), 32'h0);
        strobe(set_rail(base, 3, uvs(nv[3])), 1);
        check("R4 one sample short", 32'(shutdown_req), 32'h0);
        strobe(set_rail(base, 3, uvs(nv[3])), 0);
        check("R4 UV shutdown asserted", 32'(shutdown_req), 32'h1);
        check("R4 uv_trip rail 3", 32'(uv_trip), 32'h8);
        check("R7 second fault not locked", 32'(fault_locked), 32'h0);
        strobe(base, 0);
        wait_run();

        // R7/R8: third fault (OV at exact limit) locks and requests bus off
        repeat (OVQ) strobe(set_rail(base, 0, ovs(nv[0])), 0);
        check("R7 locked after budget", 32'(fault_locked), 32'h1);
        check("R8 bus off on OV lockout", 32'(bus_off_req), 32'h1);
        repeat (2 * RSTC) strobe(base, 0);
        check("R7 lock persists", 32'({shutdown_req, fault_locked}), 32'h3);
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
        check("R7 clear releases", 32'({shutdown_req, fault_locked, bus_off_req}), 32'h0);
        check("R7 clear drops trips", 32'({ov_trip, uv_trip}), 32'h0);

        // R7: budget restored; R8: UV-only lockout keeps bus on
        for (int k = 0; k < MAXR; k++) begin
            repeat (UVQ) strobe(set_rail(base, 1, uvs(nv[1])), 0);
            check("R7 restored budget gives hold-off", 32'({shutdown_req, fault_locked}), 32'h2);
            strobe(base, 0);
            wait_run();
        end
        repeat (UVQ) strobe(set_rail(base, 1, uvs(nv[1])), 0);
        check("R7 UV lockout", 32'(fault_locked), 32'h1);
        check("R8 no bus off for UV lockout", 32'(bus_off_req), 32'h0);
        fault_clear = 1'b1;
        @(negedge clk);
        fault_clear = 1'b0;
        repeat (3) strobe(base, 0);
        check("R7 final release", 32'(shutdown_req), 32'h0);
        report();
    end
endmodule